// File: doc/BRIEF.md
# 16-bit ALU with condition flags

This is the purely combinational arithmetic and logic unit of a small eight-register processor datapath. Each evaluation takes two 16-bit operands, a 4-bit operation code and the current carry flag. It returns a 16-bit result, a write-enable that says whether the result is meant for the destination register, and the next zero, carry, negative and overflow flags.

The surrounding pipeline selects the operands, latches the flags and performs register write-back. The unit has no state. Its outputs follow its inputs within the same cycle. Operations fall into three families: arithmetic (carry and overflow are computed), bitwise and move (carry and overflow are cleared), and shift/rotate (shift amount taken from the second operand).

Top module: `alu16_core`

## Requirements
- R1: ADD (op 0) gives res = a+b and ADC (op 2) gives res = a+b+cin, each modulo 2^16. Carry-out is bit 16 of the unsigned sum, computed at 17 bits.
- R2: SUB (op 1) gives a-b, SBB (op 3) gives a-b-cin and NEG (op 8) gives 0-a, each modulo 2^16. Carry-out is set when the unsigned 17-bit difference borrows; for NEG this means a is not zero.
- R3: Overflow flag. For ADD and ADC it is set when a and b have equal sign bits (bit 15) and the result's sign bit differs from them. For SUB, SBB and CMP the test uses the inverted sign of b. For NEG it is set only when a = 0x8000.
- R4: For every operation, z is set exactly when res is zero, and n equals res bit 15.
- R5: AND (op 4), OR (op 5), XOR (op 6), NOT of a (op 7) and MOV of b (op 9) give the expected bitwise result, with carry and overflow both 0.
- R6: CMP (op 10) puts out a-b and the same flags as SUB, with wr_o = 0. Every other opcode drives wr_o = 1.
- R7: SHL (op 11) and SHR (op 12) shift a by b[3:0] only; the upper bits of b are ignored. Carry for SHL is the last bit shifted out, and 0 for an amount of 0. Carry for SHR is 0. Overflow is 0 for both.
- R8: SAR (op 13) shifts a right by the whole value of b and fills with a[15]. An amount of 16 or more gives sixteen copies of a[15]. Carry and overflow are 0.
- R9: ROL (op 14) rotates a left within 16 bits by b[3:0]. An amount of 0 returns a unchanged. Carry and overflow are 0.
- R10: RCL (op 15) forms the 17-bit value {cin, a}, rotates it left by b[3:0], puts out the low 16 bits as res, and puts out bit 16 as the carry. Overflow is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | 16 | First operand (destination register value) |
| b_i | input | 16 | Second operand, also the shift amount |
| c_i | input | 1 | Incoming carry flag |
| res_o | output | 16 | Result |
| wr_o | output | 1 | Result is to be written back |
| z_o | output | 1 | Next zero flag |
| c_o | output | 1 | Next carry flag |
| n_o | output | 1 | Next negative flag |
| v_o | output | 1 | Next overflow flag |

## Verification
Operand pairs are chosen around the carry and sign boundaries: 0xFFFF+1, 0x7FFF+1, 0x8000-1, 0-1 and negation of 0x8000 and of zero. These separate carry out of bit 16 from signed overflow, and separate borrow from no borrow. Shift operands carry amounts whose upper bits are set (17, 0x10, 20). These show whether the design masks the amount to four bits, or for the arithmetic right shift saturates it. Rotates by 0 and 1, with the carry in both states, distinguish the 16-bit rotate from the 17-bit rotate. A long run of pseudo-random opcodes and operands is compared against an integer model on every clock.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,  OP_SUB = 4'd1,  OP_ADC = 4'd2,  OP_SBB = 4'd3,
    OP_AND = 4'd4,  OP_OR  = 4'd5,  OP_XOR = 4'd6,  OP_NOT = 4'd7,
    OP_NEG = 4'd8,  OP_MOV = 4'd9,  OP_CMP = 4'd10, OP_SHL = 4'd11,
    OP_SHR = 4'd12, OP_SAR = 4'd13, OP_ROL = 4'd14, OP_RCL = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic v;
  } cv_t;
endpackage

// File: rtl/alu16_arith.sv
module alu16_arith
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e        op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           c_i,
  output logic [W-1:0]   res_o,
  output cv_t            cv_o
);
  localparam int MSB = W - 1;

  logic [W:0] ax, bx, cx, t;
  logic       sub_like;

  always_comb begin
    ax       = {1'b0, a_i};
    bx       = {1'b0, b_i};
    cx       = {{W{1'b0}}, c_i};
    sub_like = 1'b0;
    case (op_i)
      OP_ADC:         t = ax + bx + cx;
      OP_SUB, OP_CMP: begin t = ax - bx;      sub_like = 1'b1; end
      OP_SBB:         begin t = ax - bx - cx; sub_like = 1'b1; end
      OP_NEG:         t = {(W+1){1'b0}} - ax;
      default:        t = ax + bx;
    endcase
    res_o  = t[W-1:0];
    cv_o.c = t[W];
    if (op_i == OP_NEG)
      cv_o.v = a_i[MSB] & ~|a_i[MSB-1:0];
    else if (sub_like)
      cv_o.v = (a_i[MSB] ^ b_i[MSB]) & (t[MSB] ^ a_i[MSB]);
    else
      cv_o.v = ~(a_i[MSB] ^ b_i[MSB]) & (t[MSB] ^ a_i[MSB]);
  end
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_NOT:  res_o = ~a_i;
      default: res_o = b_i;  // move
    endcase
  end
endmodule

// File: rtl/alu16_shift.sv
module alu16_shift
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] res_o,
  output logic         c_o
);
  localparam int SW = $clog2(W);

  logic [SW-1:0] amt;
  logic          sar_sat;
  logic [W:0]    shl_x, rcl_in, rcl_x;
  logic [W-1:0]  rol_x, sar_x;

  assign amt     = b_i[SW-1:0];
  assign sar_sat = |b_i[W-1:SW];

  always_comb begin
    shl_x  = {1'b0, a_i} << amt;
    rcl_in = {c_i, a_i};
    // right part is empty for amt 0 since shift by W+1 clears it
    rcl_x  = (rcl_in << amt) | (rcl_in >> ((W + 1) - int'(amt)));
    rol_x  = (amt == '0) ? a_i : ((a_i << amt) | (a_i >> (W - int'(amt))));
    sar_x  = sar_sat ? {W{a_i[W-1]}} : W'($signed(a_i) >>> amt);
    c_o    = 1'b0;
    case (op_i)
      OP_SHL:  begin res_o = shl_x[W-1:0]; c_o = shl_x[W]; end
      OP_SHR:  res_o = a_i >> amt;
      OP_SAR:  res_o = sar_x;
      OP_ROL:  res_o = rol_x;
      OP_RCL:  begin res_o = rcl_x[W-1:0]; c_o = rcl_x[W]; end
      default: res_o = a_i;
    endcase
  end
endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] res_o,
  output logic         wr_o,
  output logic         z_o,
  output logic         c_o,
  output logic         n_o,
  output logic         v_o
);
  alu_op_e      op;
  logic [W-1:0] ar_res, lg_res, sh_res;
  cv_t          ar_cv;
  logic         sh_c;

  assign op = alu_op_e'(op_i);

  alu16_arith #(.W(W)) u_arith (
    .op_i(op), .a_i(a_i), .b_i(b_i), .c_i(c_i), .res_o(ar_res), .cv_o(ar_cv)
  );

  alu16_logic #(.W(W)) u_logic (
    .op_i(op), .a_i(a_i), .b_i(b_i), .res_o(lg_res)
  );

  alu16_shift #(.W(W)) u_shift (
    .op_i(op), .a_i(a_i), .b_i(b_i), .c_i(c_i), .res_o(sh_res), .c_o(sh_c)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_SUB, OP_ADC, OP_SBB, OP_NEG, OP_CMP: begin
        res_o = ar_res; c_o = ar_cv.c; v_o = ar_cv.v;
      end
      OP_SHL, OP_SHR, OP_SAR, OP_ROL, OP_RCL: begin
        res_o = sh_res; c_o = sh_c; v_o = 1'b0;
      end
      default: begin
        res_o = lg_res; c_o = 1'b0; v_o = 1'b0;
      end
    endcase
    z_o  = (res_o == '0);
    n_o  = res_o[W-1];
    wr_o = (op != OP_CMP);
  end
endmodule

// File: rtl/alu16_core_chk.sv
module alu16_core_chk #(
  parameter int W = 16
) (
  input logic [3:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         c_i,
  input logic [W-1:0] res_o,
  input logic         wr_o,
  input logic         z_o,
  input logic         c_o,
  input logic         n_o,
  input logic         v_o
);
  always_comb begin
    // R6
    wr_gate_chk: assert (wr_o == (op_i != 4'd10))
      else $error("wr_o wrong for op %0d", op_i);
    // R4
    zero_flag_chk: assert (z_o == (res_o == '0))
      else $error("z_o disagrees with res_o");
    // R4
    neg_flag_chk: assert (n_o == res_o[W-1])
      else $error("n_o disagrees with res_o sign");
    // R5
    if (op_i inside {4'd4, 4'd5, 4'd6, 4'd7, 4'd9}) begin
      logic_cv_clear_chk: assert (!c_o && !v_o)
        else $error("carry/overflow not cleared on logic op");
    end
    // R9
    if (op_i == 4'd14 && b_i[3:0] == 4'd0) begin
      rol_zero_chk: assert (res_o == a_i)
        else $error("rotate by 0 altered operand");
    end
    // R8
    if (op_i == 4'd13 && b_i >= W[W-1:0]) begin
      sar_sat_chk: assert (res_o == {W{a_i[W-1]}})
        else $error("saturated arithmetic shift wrong");
    end
    // R10
    if (op_i == 4'd15 && b_i[3:0] == 4'd0) begin
      rcl_zero_chk: assert (res_o == a_i && c_o == c_i)
        else $error("rotate through carry by 0 altered state");
    end
  end
endmodule

bind alu16_core alu16_core_chk #(.W(W)) u_chk (
  .op_i(op_i), .a_i(a_i), .b_i(b_i), .c_i(c_i), .res_o(res_o), .wr_o(wr_o),
  .z_o(z_o), .c_o(c_o), .n_o(n_o), .v_o(v_o)
);

// File: tb/alu16_core_tb_top.sv
module alu16_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [15:0] a = 16'd0, b = 16'd0;
  logic        cin = 1'b0;
  logic [15:0] res;
  logic        wr, z, c, n, v;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu16_core dut_i (
    .op_i(op), .a_i(a), .b_i(b), .c_i(cin),
    .res_o(res), .wr_o(wr), .z_o(z), .c_o(c), .n_o(n), .v_o(v)
  );

  // Behavioural reference: integers and bit-at-a-time loops.
  task automatic model(input int o, input int ai, input int bi, input int ci,
                       output int r, output int ec, output int ev);
    int s, sa, sb, sv, cnt;
    logic [16:0] x;
    logic [15:0] y;
    sa = (ai >= 32768) ? ai - 65536 : ai;
    sb = (bi >= 32768) ? bi - 65536 : bi;
    ec = 0; ev = 0; s = 0; sv = 0;
    case (o)
      0, 2: begin
        s = ai + bi + ((o == 2) ? ci : 0);
        sv = sa + sb + ((o == 2) ? ci : 0);
        ec = (s > 65535) ? 1 : 0;
      end
      1, 3, 10: begin
        s = ai - bi - ((o == 3) ? ci : 0);
        sv = sa - sb - ((o == 3) ? ci : 0);
        ec = (s < 0) ? 1 : 0;
      end
      8: begin
        s = -ai; sv = -sa; ec = (s < 0) ? 1 : 0;
      end
      4: s = ai & bi;
      5: s = ai | bi;
      6: s = ai ^ bi;
      7: s = (~ai) & 65535;
      9: s = bi;
      11: begin
        y = 16'(ai);
        for (int i = 0; i < (bi % 16); i++) begin ec = int'(y[15]); y = y << 1; end
        s = int'(y);
      end
      12: begin
        y = 16'(ai);
        for (int i = 0; i < (bi % 16); i++) y = y >> 1;
        s = int'(y);
      end
      13: begin
        y = 16'(ai);
        cnt = (bi > 20) ? 20 : bi;
        for (int i = 0; i < cnt; i++) y = {y[15], y[15:1]};
        s = int'(y);
      end
      14: begin
        y = 16'(ai);
        for (int i = 0; i < (bi % 16); i++) y = {y[14:0], y[15]};
        s = int'(y);
      end
      default: begin
        x = {1'(ci), 16'(ai)};
        for (int i = 0; i < (bi % 16); i++) x = {x[15:0], x[16]};
        s = int'(x[15:0]); ec = int'(x[16]);
      end
    endcase
    if (o inside {0, 1, 2, 3, 8, 10})
      ev = (sv > 32767 || sv < -32768) ? 1 : 0;
    r = s & 65535;
  endtask

  function automatic string req_of(input int o);
    case (o)
      0, 2:        return "R1/R3";
      1, 3:        return "R2/R3";
      8:           return "R2/R3 neg";
      4, 5, 6, 7, 9: return "R5";
      10:          return "R6";
      11, 12:      return "R7";
      13:          return "R8";
      14:          return "R9";
      default:     return "R10";
    endcase
  endfunction

  task automatic run(input int o, input int ai, input int bi, input int ci);
    int r, ec, ev, ew;
    @(posedge clk);
    #1;
    op = 4'(o); a = 16'(ai); b = 16'(bi); cin = 1'(ci);
    @(negedge clk);
    model(o, ai, bi, ci, r, ec, ev);
    ew = (o == 10) ? 0 : 1;
    total++;
    if (int'(res) != r || int'(c) != ec || int'(v) != ev) begin
      bad++;
      $display("FAIL %s op=%0d a=%h b=%h cin=%0d actual res=%h c=%0d v=%0d expected res=%h c=%0d v=%0d",
               req_of(o), o, ai[15:0], bi[15:0], ci, res, c, v, r[15:0], ec, ev);
    end
    total++;
    if (int'(z) != ((r == 0) ? 1 : 0) || int'(n) != ((r >> 15) & 1) || int'(wr) != ew) begin
      bad++;
      $display("FAIL R4/R6 op=%0d actual z=%0d n=%0d wr=%0d expected z=%0d n=%0d wr=%0d",
               o, z, n, wr, (r == 0), (r >> 15) & 1, ew);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  initial begin : watchdog
    while (cycles < MAX_CYCLES && !done) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog all R actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    int r, ec, ev;
    repeat (3) @(posedge clk);
    // reset state: ADD 0+0 with zero inputs, R4
    @(negedge clk);
    total++;
    if (res !== 16'h0 || z !== 1'b1 || c !== 1'b0 || v !== 1'b0 || wr !== 1'b1) begin
      bad++;
      $display("FAIL R4 reset actual res=%h z=%0d expected res=0000 z=1", res, z);
    end
    rst_ni = 1'b1;
    // R1 carry out and overflow
    run(0, 'hFFFF, 1, 0);
    run(0, 'h7FFF, 1, 0);
    run(2, 'hFFFE, 1, 1);
    run(2, 'h7FFF, 0, 1);
    // R2 borrow, R3 sub overflow
    run(1, 0, 1, 0);
    run(1, 'h8000, 1, 0);
    run(1, 'hFFFF, 'h8000, 0);
    run(3, 5, 5, 1);
    run(8, 'h8000, 0, 0);
    run(8, 0, 0, 1);
    run(8, 1, 0, 0);
    // R5
    run(4, 'hF0F0, 'h3C3C, 1);
    run(5, 'hF0F0, 'h0F0F, 1);
    run(6, 'hAAAA, 'hAAAA, 1);
    run(7, 'h0000, 0, 1);
    run(9, 0, 'h8001, 1);
    // R6 compare
    run(10, 3, 3, 0);
    run(10, 'h8000, 1, 0);
    // R7 amount masked to 4 bits
    run(11, 'h8001, 17, 0);
    run(11, 'h4000, 2, 0);
    run(12, 'h8001, 'h10, 1);
    run(12, 'hF000, 'h0F04, 0);
    // R8
    run(13, 'h8000, 20, 0);
    run(13, 'h4000, 20, 0);
    run(13, 'h8010, 3, 0);
    run(13, 'h8000, 16, 0);
    // R9
    run(14, 'h1234, 0, 1);
    run(14, 'h8001, 4, 0);
    run(14, 'h8001, 'h21, 0);
    // R10
    run(15, 'h8000, 1, 1);
    run(15, 'h1234, 0, 1);
    run(15, 'h0001, 15, 1);
    run(15, 'hFFFF, 8, 0);
    // pseudo-random sweep over all opcodes
    for (int k = 0; k < 3000; k++) begin
      seed = nxt(seed);
      r = int'(seed[15:0]);
      seed = nxt(seed);
      ec = (seed[2:0] == 3'd0) ? int'(seed[20:16]) : int'(seed[31:16]);
      ev = int'(seed[7]);
      run(int'(seed[11:8]), r, ec, ev);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule